// File: doc/BRIEF.md
# Banked Memory Mapper with Automatic Disk-ROM Paging

This block maps the 64 KB address space of an 8-bit CPU onto physical memory in four 16 KB windows. A paging register, loaded by an I/O write, chooses the RAM page seen in the top window, the RAM page the video circuit displays, and the ROM image visible in the bottom window. The two middle windows are fixed to RAM pages 5 and 2.

The block also watches opcode fetches so that the disk-interface ROM can be overlaid on the bottom window without any register write. When the 48K BASIC image is selected and the CPU fetches an instruction from the 256-byte block starting at 0x3D00, the disk ROM replaces it. The first instruction fetched from 0x4000 or above removes the overlay again.

The outputs are page numbers and an image code, meant to be combined with the low 14 CPU address bits by the memory decoder. The block also gives a strobe that marks any write into the read-only bottom window, so the decoder can suppress it. A configuration input selects a board variant that has a third ROM image.

Top module: `bank_mapper`

## Requirements
- R1: `win1_page` is always 5 and `win2_page` is always 2, for any register value.
- R2: `win3_page` equals bits 2:0 of the paging register.
- R3: `video_page` is 7 when bit 3 of the paging register is 1 and 5 when it is 0.
- R4: `rom_img` codes are 0 = 128K-mode ROM, 1 = 48K BASIC ROM, 2 = variant ROM, 3 = disk ROM. When the disk ROM is not active, a register write makes `rom_img` equal to bit 4 of the written value.
- R5: An opcode fetch (`mem_fetch`=1) with address bits 15:8 equal to 0x3D, while `rom_img` is 1, sets `rom_img` to 3 and `disk_rom_active` to 1. The same fetch while `rom_img` is 0 has no effect.
- R6: While `disk_rom_active` is 1, an opcode fetch at address 0x4000 or above clears `disk_rom_active` and sets `rom_img` to bit 4 of the paging register. A fetch below 0x4000 leaves both unchanged.
- R7: `rom_wr_block` is 1 exactly when `mem_wr` is 1 and `mem_addr` is below 0x4000.
- R8: While `rst_n` is low at a clock edge, the paging register clears to 0, `disk_rom_active` becomes 1 and `rom_img` becomes 3.
- R9: A register write with bit 4 clear, made while `disk_rom_active` is 1, sets `rom_img` to 2 if `variant_sel` is 1 and to 0 if it is 0. `disk_rom_active` stays 1.
- R10: An I/O write loads the register only when `io_addr` bit 15 and bit 1 are both 0. Other I/O writes change no output.
- R11: Register writes and fetch-triggered changes appear on the outputs in the cycle after the clock edge that samples them. The triggering fetch cycle still sees the old mapping.
- R12: A memory access with `mem_fetch`=0 at 0x3Dxx or at 0x4000 and above does not change `rom_img` or `disk_rom_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| mem_addr | input | 16 | Memory address of the current access |
| mem_fetch | input | 1 | Current access is an opcode fetch |
| mem_wr | input | 1 | Current access is a memory write |
| variant_sel | input | 1 | Board variant with a third ROM image |
| rom_img | output | 2 | Image in the bottom window (0 128K, 1 48K, 2 variant, 3 disk) |
| disk_rom_active | output | 1 | Disk ROM overlay is engaged |
| win1_page | output | 3 | RAM page for 0x4000-0x7FFF |
| win2_page | output | 3 | RAM page for 0x8000-0xBFFF |
| win3_page | output | 3 | RAM page for 0xC000-0xFFFF |
| video_page | output | 3 | RAM page shown by the video circuit |
| rom_wr_block | output | 1 | Write into the bottom window, to be suppressed |

## Verification
Every page, image and overlay output is registered. Each one changes exactly one clock edge after the write or fetch that causes it, and `rom_wr_block` is combinational within the same cycle. The bench drives each stimulus on a falling edge and holds it over one rising edge. It then compares every output with its own model at the following falling edge. For fetch stimuli it also samples before that rising edge, to show that the triggering fetch still sees the old image.

// File: rtl/mapper_pkg.sv
// mapper_pkg: shared types and constants for the banked memory mapper.
// Assumes a 2-bit image code is enough for the four bottom-window images.
package mapper_pkg;
    typedef enum logic [1:0] {
        IMG_128  = 2'd0,
        IMG_48   = 2'd1,
        IMG_ALT  = 2'd2,
        IMG_DISK = 2'd3
    } rom_img_t;
endpackage

// File: rtl/page_reg.sv
// page_reg: decodes I/O writes to the paging register and holds its value.
// Assumes only address bits ADDR_W-1 and DEC_BIT take part in the decode.
module page_reg #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int DEC_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic              pg_wr,
    output logic [DATA_W-1:0] pg_q
);
    // Address match for the paging port: both decode bits low.
    always_comb begin
        pg_wr = io_wr && !io_addr[ADDR_W-1] && !io_addr[DEC_BIT];
    end

    // Paging register storage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pg_q <= '0;
        else if (pg_wr)
            pg_q <= io_wdata;
    end
endmodule

// File: rtl/rom_pager.sv
// rom_pager: chooses the bottom-window ROM image and runs the disk-ROM
// overlay. It assumes a register write and an opcode fetch never arrive in the
// same cycle; if they do, the write takes priority.
module rom_pager
    import mapper_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter int          WIN_W   = 2,
    parameter logic [7:0]  TRAP_HI = 8'h3D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_wr,
    input  logic              wr_sel48,
    input  logic              pg_sel48,
    input  logic              variant_sel,
    input  logic              mem_fetch,
    input  logic [ADDR_W-1:0] mem_addr,
    output rom_img_t          rom_img,
    output logic              disk_act
);
    localparam int HI_W = 8;

    rom_img_t rom_q, rom_d;
    logic     act_q, act_d;
    logic     trap_hit, leave_hit;

    // Fetch qualifiers: entry into and exit from the disk overlay.
    always_comb begin
        trap_hit  = mem_fetch && (mem_addr[ADDR_W-1 -: HI_W] == TRAP_HI)
                    && (rom_q == IMG_48);
        leave_hit = mem_fetch && act_q && (mem_addr[ADDR_W-1 -: WIN_W] != '0);
    end

    // Next-state selection, with priority write, then exit, then entry.
    always_comb begin
        rom_d = rom_q;
        act_d = act_q;
        if (pg_wr) begin
            if (act_q && !wr_sel48)
                rom_d = variant_sel ? IMG_ALT : IMG_128;
            else
                rom_d = wr_sel48 ? IMG_48 : IMG_128;
        end else if (leave_hit) begin
            act_d = 1'b0;
            rom_d = pg_sel48 ? IMG_48 : IMG_128;
        end else if (trap_hit) begin
            act_d = 1'b1;
            rom_d = IMG_DISK;
        end
    end

    // Image and overlay state registers; reset engages the disk ROM.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_q <= IMG_DISK;
            act_q <= 1'b1;
        end else begin
            rom_q <= rom_d;
            act_q <= act_d;
        end
    end

    assign rom_img  = rom_q;
    assign disk_act = act_q;
endmodule

// File: rtl/window_map.sv
// window_map: turns the paging register into per-window RAM pages, the video
// page and the write-block strobe for the read-only bottom window.
// Assumes NWIN windows of equal size and a fixed page for each middle window.
module window_map #(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 8,
    parameter int          PAGE_W     = 3,
    parameter int          NWIN       = 4,
    parameter logic [5:0]  FIXED_PGS  = {3'd2, 3'd5},
    parameter logic [2:0]  VID_NORM   = 3'd5,
    parameter logic [2:0]  VID_ALT    = 3'd7,
    parameter int          VID_BIT    = 3
) (
    input  logic [DATA_W-1:0]          pg_q,
    input  logic                       mem_wr,
    input  logic [ADDR_W-1:0]          mem_addr,
    output logic [(NWIN-2)*PAGE_W-1:0] fix_pages,
    output logic [PAGE_W-1:0]          top_page,
    output logic [PAGE_W-1:0]          video_page,
    output logic                       rom_wr_block
);
    localparam int WIN_W = $clog2(NWIN);
    localparam int NFIX  = NWIN - 2;

    // One constant page per fixed middle window.
    for (genvar w = 0; w < NFIX; w++) begin : g_fix
        assign fix_pages[w*PAGE_W +: PAGE_W] = FIXED_PGS[w*PAGE_W +: PAGE_W];
    end

    // Switchable top page and video page from the register.
    always_comb begin
        top_page   = pg_q[PAGE_W-1:0];
        video_page = pg_q[VID_BIT] ? VID_ALT : VID_NORM;
    end

    // Flag any write aimed at the bottom (ROM) window.
    always_comb begin
        rom_wr_block = mem_wr && (mem_addr[ADDR_W-1 -: WIN_W] == '0);
    end
endmodule

// File: rtl/bank_mapper.sv
// bank_mapper: top of the banked memory mapper. It joins the register, the
// ROM pager and the window decoder. Assumes a single clock and a synchronous
// active-low reset.
module bank_mapper
    import mapper_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int PAGE_W  = 3,
    parameter int ROM_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_fetch,
    input  logic              mem_wr,
    input  logic              variant_sel,
    output logic [1:0]        rom_img,
    output logic              disk_rom_active,
    output logic [PAGE_W-1:0] win1_page,
    output logic [PAGE_W-1:0] win2_page,
    output logic [PAGE_W-1:0] win3_page,
    output logic [PAGE_W-1:0] video_page,
    output logic              rom_wr_block
);
    localparam int NWIN = 4;

    logic                       pg_wr;
    logic [DATA_W-1:0]          pg_q;
    rom_img_t                   img;
    logic [(NWIN-2)*PAGE_W-1:0] fix_pages;

    page_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .pg_wr(pg_wr), .pg_q(pg_q)
    );

    rom_pager #(.ADDR_W(ADDR_W)) u_pager (
        .clk(clk), .rst_n(rst_n), .pg_wr(pg_wr),
        .wr_sel48(io_wdata[ROM_BIT]), .pg_sel48(pg_q[ROM_BIT]),
        .variant_sel(variant_sel), .mem_fetch(mem_fetch),
        .mem_addr(mem_addr), .rom_img(img), .disk_act(disk_rom_active)
    );

    window_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W),
                 .NWIN(NWIN)) u_win (
        .pg_q(pg_q), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .fix_pages(fix_pages), .top_page(win3_page),
        .video_page(video_page), .rom_wr_block(rom_wr_block)
    );

    assign rom_img   = img;
    assign win1_page = fix_pages[0 +: PAGE_W];
    assign win2_page = fix_pages[PAGE_W +: PAGE_W];
endmodule

// File: rtl/bank_mapper_chk.sv
// bank_mapper_chk: timing properties of the mapper, bound to bank_mapper.
module bank_mapper_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        io_wr,
    input logic [15:0] io_addr,
    input logic [7:0]  io_wdata,
    input logic [15:0] mem_addr,
    input logic        mem_fetch,
    input logic [1:0]  rom_img,
    input logic        disk_rom_active,
    input logic [2:0]  win3_page,
    input logic [2:0]  video_page
);
    logic reg_hit;
    assign reg_hit = io_wr && !io_addr[15] && !io_addr[1];

    // R2
    top_page_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_hit |=> win3_page == $past(io_wdata[2:0]));

    // R3
    video_page_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_hit |=> video_page == ($past(io_wdata[3]) ? 3'd7 : 3'd5));

    // R5
    disk_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_hit && mem_fetch && mem_addr[15:8] == 8'h3D && rom_img == 2'd1)
        |=> (rom_img == 2'd3 && disk_rom_active));

    // R6
    disk_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_hit && mem_fetch && disk_rom_active && mem_addr[15:14] != 2'b00)
        |=> !disk_rom_active);

    // R8
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (rom_img == 2'd3 && disk_rom_active && win3_page == 3'd0));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_hit && !mem_fetch) |=> ($stable(rom_img) && $stable(disk_rom_active)));
endmodule

bind bank_mapper bank_mapper_chk u_chk (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .mem_addr(mem_addr), .mem_fetch(mem_fetch),
    .rom_img(rom_img), .disk_rom_active(disk_rom_active),
    .win3_page(win3_page), .video_page(video_page)
);

// File: tb/sim_bank_mapper.sv
`timescale 1ns/1ps
module sim_bank_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [15:0] mem_addr = '0;
    logic        mem_fetch = 1'b0;
    logic        mem_wr = 1'b0;
    logic        variant_sel = 1'b0;
    logic [1:0]  rom_img;
    logic        disk_rom_active;
    logic [2:0]  win1_page, win2_page, win3_page, video_page;
    logic        rom_wr_block;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state
    logic [7:0] m_pg;
    logic       m_act;
    logic [1:0] m_rom;

    always #4 clk = ~clk;

    bank_mapper u0 (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .mem_addr(mem_addr), .mem_fetch(mem_fetch),
        .mem_wr(mem_wr), .variant_sel(variant_sel), .rom_img(rom_img),
        .disk_rom_active(disk_rom_active), .win1_page(win1_page),
        .win2_page(win2_page), .win3_page(win3_page),
        .video_page(video_page), .rom_wr_block(rom_wr_block)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare every registered output with the model.
    task automatic check_all(input string req);
        chk({req, "/R1 win1"}, win1_page, 5);
        chk({req, "/R1 win2"}, win2_page, 2);
        chk({req, "/R2 win3"}, win3_page, m_pg[2:0]);
        chk({req, "/R3 video"}, video_page, m_pg[3] ? 7 : 5);
        chk({req, " rom_img"}, rom_img, m_rom);
        chk({req, " disk_act"}, disk_rom_active, m_act);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_pg = 8'h00; m_act = 1'b1; m_rom = 2'd3;
        check_all("R8 reset");
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d,
                            input string req);
        logic hit;
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        hit = !a[15] && !a[1];
        @(negedge clk);
        io_wr = 1'b0;
        if (hit) begin
            if (m_act && !d[4]) m_rom = variant_sel ? 2'd2 : 2'd0;
            else                m_rom = {1'b0, d[4]};
            m_pg = d;
        end
        check_all(req);
    endtask

    // Opcode fetch (f=1) or plain access (f=0); checks the old image in-cycle (R11).
    task automatic mem_access(input logic [15:0] a, input logic f, input string req);
        @(negedge clk);
        mem_addr = a; mem_fetch = f;
        #1 chk({req, "/R11 same-cycle"}, rom_img, m_rom);
        @(negedge clk);
        mem_fetch = 1'b0;
        if (f) begin
            if (m_act && a[15:14] != 2'b00) begin
                m_act = 1'b0; m_rom = {1'b0, m_pg[4]};
            end else if (a[15:8] == 8'h3D && m_rom == 2'd1) begin
                m_act = 1'b1; m_rom = 2'd3;
            end
        end
        check_all(req);
    endtask

    task automatic test_protect();
        @(negedge clk);
        mem_wr = 1'b1; mem_addr = 16'h3FFF;
        #1 chk("R7 low write", rom_wr_block, 1);
        mem_addr = 16'h0000;
        #1 chk("R7 zero write", rom_wr_block, 1);
        mem_addr = 16'h4000;
        #1 chk("R7 ram write", rom_wr_block, 0);
        mem_wr = 1'b0; mem_addr = 16'h1000;
        #1 chk("R7 read", rom_wr_block, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R9 non-variant: write bit4=0 while disk active -> 128K image
        io_write(16'h7FFD, 8'h03, "R9 plain");
        mem_access(16'h2000, 1'b1, "R6 low fetch keeps");
        mem_access(16'h4000, 1'b1, "R6 leave");
        io_write(16'h7FFD, 8'h0E, "R2 R3 page6 video7");
        io_write(16'h7FFD, 8'h15, "R4 48K");
        io_write(16'hFFFD, 8'h07, "R10 bit15 set");
        io_write(16'h7FFF, 8'h02, "R10 bit1 set");
        io_write(16'h0001, 8'h11, "R10 minimal decode");
        mem_access(16'h3D10, 1'b0, "R12 non-fetch 3D");
        mem_access(16'h3C00, 1'b1, "R5 near miss");
        mem_access(16'h3DFF, 1'b1, "R5 trap");
        mem_access(16'h8000, 1'b0, "R12 non-fetch high");
        mem_access(16'hC123, 1'b1, "R6 leave to 48K");
        io_write(16'h7FFD, 8'h07, "R4 128K");
        mem_access(16'h3D00, 1'b1, "R5 no trap on 128K");
        test_protect();
        // R9 variant image
        do_reset();
        variant_sel = 1'b1;
        io_write(16'h7FFD, 8'h00, "R9 variant");
        io_write(16'h7FFD, 8'h10, "R9 bit4 set");
        mem_access(16'h3D40, 1'b1, "R5 trap while active");
        mem_access(16'h4000, 1'b1, "R6 leave after trap");
        variant_sel = 1'b0;
        do_reset();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule